// File: doc/BRIEF.md
# Reset Strap Sampler with Snoop Address Matcher

This block lets two board pins do double duty. While reset is held, the pins are inputs that carry configuration straps. When reset ends, their levels are captured once into registers, and from then on the same pins drive LEDs. One strap records whether an external serial EEPROM is fitted. The other strap sets how much of a snooped bus address must equal a programmed relocation address before a hit is reported.

The reset input is asynchronous and active low. It is first brought into the clock domain, and the straps are captured on the clock edge at which the synchronized release is detected. On that same edge the LED drivers turn on. After that, each LED level is the activity input with an optional inversion.

A snoop comparison runs on every cycle in which the snoop strobe is high. In wide mode all 32 address bits take part. In narrow mode only the low 24 bits take part, and the top byte always counts as equal. The hit output is registered.

Top module: `strap_snoop_unit`

## Requirements
- R1: While `rst_n` is low, `led_oe`, `led_out`, `snoop_hit`, `eeprom_found` and `addr_wide` are all 0.
- R2: The straps are captured on the third rising clock edge at which `rst_n` is high after a release. `led_oe` becomes 2'b11 on that same edge and is still 0 after the second edge.
- R3: `eeprom_found` equals the level of `strap_a_pin` at the capture edge. 1 means an EEPROM is present and 0 means none.
- R4: `addr_wide` equals the level of `strap_b_pin` at the capture edge. 1 selects the 32-bit comparison and 0 selects the 24-bit comparison.
- R5: Once captured, `eeprom_found` and `addr_wide` keep their values until the next reset, whatever the strap pins do later.
- R6: In wide mode, `snoop_hit` is 1 in the cycle after a strobed `snoop_addr` equals `reloc_addr` on all 32 bits. It is 0 if any bit differs.
- R7: In narrow mode, only bits 23:0 are compared. Bits 31:24 never prevent a hit.
- R8: `snoop_hit` is 0 in the cycle after a cycle with `snoop_vld` low, and 0 in every cycle before `led_oe` has gone high.
- R9: While `led_oe` is high, `led_out[i]` = `led_act[i]` XOR `led_pol[i]`, so a polarity bit of 1 inverts the drive. While `led_oe` is low, `led_out` is 0.
- R10: Pulling `rst_n` low while the block is running clears all outputs at once, without waiting for a clock edge. The next release captures the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_a_pin | input | 1 | Pad level of the EEPROM-detect strap / LED 0 pin |
| strap_b_pin | input | 1 | Pad level of the address-width strap / LED 1 pin |
| led_act | input | 2 | LED activity levels from the event logic |
| led_pol | input | 2 | LED polarity control, 1 inverts |
| led_out | output | 2 | LED drive levels |
| led_oe | output | 2 | LED output-driver enables |
| snoop_addr | input | 32 | Snooped bus address |
| snoop_vld | input | 1 | Snooped address strobe |
| reloc_addr | input | 32 | Programmed relocation address |
| snoop_hit | output | 1 | Registered snoop match |
| eeprom_found | output | 1 | Captured EEPROM-present status |
| addr_wide | output | 1 | Captured width select, 1 means 32-bit |

## Verification
The properties assume that the strap pins are stable across the capture edge. They also assume that the snoop inputs and the relocation address change only between clock edges, and that `reloc_addr` is steady over a comparison. The bench drives every input on the falling edge and holds the straps until after the capture edge has passed. Only then does it flip the straps, to show that the captured values are kept. Reset is asserted only on falling edges, so the asynchronous clear never races a capture.

// File: rtl/strap_snoop_pkg.sv
package strap_snoop_pkg;

   localparam int STRAP_CNT = 2;

   typedef struct packed {
      logic addr_wide;
      logic ee_present;
   } strap_t;

endpackage

// File: rtl/rst_edge_sync.sv
module rst_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic capture_o,
   output logic active_o
);
   localparam int TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("rst_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   act_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         sync_q <= '0;
         act_q  <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
         act_q  <= sync_q[TOP];
      end
   end

   // high for the single cycle in which the synchronized release is first seen
   assign capture_o = sync_q[TOP] & ~act_q;
   assign active_o  = act_q;

endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
   parameter int NUM_STRAPS = 2
) (
   input  logic                  clk,
   input  logic                  arst_n,
   input  logic                  capture,
   input  logic [NUM_STRAPS-1:0] pins_i,
   output logic [NUM_STRAPS-1:0] straps_o
);
   generate
      for (genvar i = 0; i < NUM_STRAPS; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)      bit_q <= 1'b0;
            else if (capture) bit_q <= pins_i[i];
         end
         assign straps_o[i] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/snoop_cmp.sv
module snoop_cmp #(
   parameter int ADDR_W   = 32,
   parameter int NARROW_W = 24
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              active,
   input  logic              wide,
   input  logic              vld,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] cmp_addr,
   output logic              hit_o
);
   logic lo_eq;
   logic hi_eq;
   logic hit_next;
   logic hit_q;

   assign lo_eq = (addr[NARROW_W-1:0] == cmp_addr[NARROW_W-1:0]);

   generate
      if (NARROW_W < ADDR_W) begin : g_split
         assign hi_eq = (addr[ADDR_W-1:NARROW_W] == cmp_addr[ADDR_W-1:NARROW_W]);
      end else begin : g_full
         assign hi_eq = 1'b1;
      end
   endgenerate

   // narrow mode treats the upper field as always equal
   assign hit_next = active & vld & lo_eq & (hi_eq | ~wide);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) hit_q <= 1'b0;
      else         hit_q <= hit_next;
   end

   assign hit_o = hit_q;

endmodule

// File: rtl/led_drive.sv
module led_drive #(
   parameter int NUM_LED = 2
) (
   input  logic               active,
   input  logic [NUM_LED-1:0] act,
   input  logic [NUM_LED-1:0] pol,
   output logic [NUM_LED-1:0] out,
   output logic [NUM_LED-1:0] oe
);
   generate
      for (genvar i = 0; i < NUM_LED; i++) begin : g_led
         assign out[i] = active & (act[i] ^ pol[i]);
         assign oe[i]  = active;
      end
   endgenerate

endmodule

// File: rtl/strap_snoop_unit.sv
module strap_snoop_unit
   import strap_snoop_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NARROW_W    = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_a_pin,
   input  logic              strap_b_pin,
   input  logic [1:0]        led_act,
   input  logic [1:0]        led_pol,
   output logic [1:0]        led_out,
   output logic [1:0]        led_oe,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic              snoop_vld,
   input  logic [ADDR_W-1:0] reloc_addr,
   output logic              snoop_hit,
   output logic              eeprom_found,
   output logic              addr_wide
);
   localparam int NUM_LED = STRAP_CNT;

   generate
      if (NARROW_W < 1 || NARROW_W > ADDR_W) begin : g_bad_width
         $error("strap_snoop_unit: NARROW_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic                 capture;
   logic                 active;
   logic [STRAP_CNT-1:0] strap_bits;
   strap_t               straps;

   rst_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .arst_n    (rst_n),
      .capture_o (capture),
      .active_o  (active)
   );

   strap_latch #(.NUM_STRAPS(STRAP_CNT)) u_latch (
      .clk      (clk),
      .arst_n   (rst_n),
      .capture  (capture),
      .pins_i   ({strap_b_pin, strap_a_pin}),
      .straps_o (strap_bits)
   );

   assign straps       = strap_t'(strap_bits);
   assign eeprom_found = straps.ee_present;
   assign addr_wide    = straps.addr_wide;

   snoop_cmp #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_cmp (
      .clk      (clk),
      .arst_n   (rst_n),
      .active   (active),
      .wide     (straps.addr_wide),
      .vld      (snoop_vld),
      .addr     (snoop_addr),
      .cmp_addr (reloc_addr),
      .hit_o    (snoop_hit)
   );

   led_drive #(.NUM_LED(NUM_LED)) u_led (
      .active (active),
      .act    (led_act),
      .pol    (led_pol),
      .out    (led_out),
      .oe     (led_oe)
   );

endmodule

// File: rtl/strap_snoop_chk.sv
module strap_snoop_chk #(
   parameter int ADDR_W   = 32,
   parameter int NARROW_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_a_pin,
   input logic              strap_b_pin,
   input logic [1:0]        led_out,
   input logic [1:0]        led_oe,
   input logic [ADDR_W-1:0] snoop_addr,
   input logic              snoop_vld,
   input logic [ADDR_W-1:0] reloc_addr,
   input logic              snoop_hit,
   input logic              eeprom_found,
   input logic              addr_wide
);
   p_capture_ee_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(led_oe[0]) |-> eeprom_found == $past(strap_a_pin));

   p_capture_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(led_oe[0]) |-> addr_wide == $past(strap_b_pin));

   p_strap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (led_oe[0] && $past(led_oe[0])) |-> ($stable(eeprom_found) && $stable(addr_wide)));

   p_wide_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (led_oe[0] && addr_wide && snoop_vld && snoop_addr == reloc_addr) |=> snoop_hit);

   p_wide_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_wide && snoop_addr != reloc_addr) |=> !snoop_hit);

   p_narrow_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (led_oe[0] && !addr_wide && snoop_vld &&
       snoop_addr[NARROW_W-1:0] == reloc_addr[NARROW_W-1:0]) |=> snoop_hit);

   p_idle_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!snoop_vld || !led_oe[0]) |=> !snoop_hit);

   p_led_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !led_oe[0] |-> led_out == 2'b00);

endmodule

bind strap_snoop_unit strap_snoop_chk #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .strap_a_pin  (strap_a_pin),
   .strap_b_pin  (strap_b_pin),
   .led_out      (led_out),
   .led_oe       (led_oe),
   .snoop_addr   (snoop_addr),
   .snoop_vld    (snoop_vld),
   .reloc_addr   (reloc_addr),
   .snoop_hit    (snoop_hit),
   .eeprom_found (eeprom_found),
   .addr_wide    (addr_wide)
);

// File: tb/strap_snoop_unit_bench.sv
module strap_snoop_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_a_pin = 1'b0;
   logic        strap_b_pin = 1'b0;
   logic [1:0]  led_act = 2'b00;
   logic [1:0]  led_pol = 2'b00;
   logic [1:0]  led_out;
   logic [1:0]  led_oe;
   logic [31:0] snoop_addr = '0;
   logic        snoop_vld = 1'b0;
   logic [31:0] reloc_addr = '0;
   logic        snoop_hit;
   logic        eeprom_found;
   logic        addr_wide;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strap_snoop_unit u_strap_snoop_unit (
      .clk(clk), .rst_n(rst_n), .strap_a_pin(strap_a_pin), .strap_b_pin(strap_b_pin),
      .led_act(led_act), .led_pol(led_pol), .led_out(led_out), .led_oe(led_oe),
      .snoop_addr(snoop_addr), .snoop_vld(snoop_vld), .reloc_addr(reloc_addr),
      .snoop_hit(snoop_hit), .eeprom_found(eeprom_found), .addr_wide(addr_wide)
   );

   // {wide mode, strobe, expected hit, address, relocation address}
   localparam logic [66:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 1'b1, 32'h1234_5678, 32'h1234_5678},
      {1'b1, 1'b1, 1'b0, 32'h1334_5678, 32'h1234_5678},
      {1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'h1234_5678},
      {1'b1, 1'b1, 1'b0, 32'h1234_5679, 32'h1234_5678},
      {1'b0, 1'b1, 1'b1, 32'hFF34_5678, 32'h1234_5678},
      {1'b0, 1'b1, 1'b1, 32'h0034_5678, 32'h1234_5678},
      {1'b0, 1'b1, 1'b0, 32'h1234_5778, 32'h1234_5678},
      {1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h1234_5678},
      {1'b0, 1'b1, 1'b1, 32'hA0AB_CDEF, 32'h5FAB_CDEF}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_reset(input logic a, input logic b);
      rst_n       = 1'b0;
      strap_a_pin = a;
      strap_b_pin = b;
      snoop_vld   = 1'b1;
      snoop_addr  = reloc_addr;
      led_act     = 2'b11;
      repeat (2) @(negedge clk);
      chk("R1 oe", {30'd0, led_oe}, 0);
      chk("R1 out", {30'd0, led_out}, 0);
      chk("R1 hit", {31'd0, snoop_hit}, 0);
      chk("R1 straps", {30'd0, addr_wide, eeprom_found}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R2 oe still off", {30'd0, led_oe}, 0);
      chk("R8 no hit before enable", {31'd0, snoop_hit}, 0);
      @(negedge clk);
      chk("R2 oe on", {30'd0, led_oe}, 2'b11);
      chk("R3 ee strap", {31'd0, eeprom_found}, {31'd0, a});
      chk("R4 width strap", {31'd0, addr_wide}, {31'd0, b});
      strap_a_pin = ~a;
      strap_b_pin = ~b;
      snoop_vld   = 1'b0;
      led_act     = 2'b00;
      repeat (3) @(negedge clk);
      chk("R5 straps held", {30'd0, addr_wide, eeprom_found}, {30'd0, b, a});
      chk("R8 no hit without strobe", {31'd0, snoop_hit}, 0);
   endtask

   initial begin
      logic mode;
      mode = 1'b0;
      for (int i = 0; i < NVEC; i++) begin
         logic [66:0] v;
         v = VEC[i];
         reloc_addr = v[31:0];
         if (i == 0 || v[66] != mode) begin
            mode = v[66];
            run_reset(~mode, mode);
         end
         snoop_vld  = v[65];
         snoop_addr = v[63:32];
         @(negedge clk);
         chk(mode ? "R6 wide compare" : "R7 narrow compare", {31'd0, snoop_hit}, {31'd0, v[64]});
      end
      snoop_vld = 1'b0;
      @(negedge clk);
      chk("R8 strobe dropped", {31'd0, snoop_hit}, 0);

      // R9 polarity
      led_act = 2'b10; led_pol = 2'b00; #1;
      chk("R9 plain", {30'd0, led_out}, 2'b10);
      led_pol = 2'b11; #1;
      chk("R9 inverted", {30'd0, led_out}, 2'b01);
      led_pol = 2'b01; #1;
      chk("R9 mixed", {30'd0, led_out}, 2'b11);
      led_act = 2'b00; led_pol = 2'b00; #1;
      chk("R9 idle", {30'd0, led_out}, 2'b00);

      // R10 asynchronous clear mid-operation, then a fresh capture
      @(negedge clk);
      led_act    = 2'b11;
      snoop_vld  = 1'b1;
      snoop_addr = reloc_addr;
      @(negedge clk);
      chk("R10 hit before clear", {31'd0, snoop_hit}, 1);
      rst_n = 1'b0; #1;
      chk("R10 hit cleared", {31'd0, snoop_hit}, 0);
      chk("R10 oe cleared", {30'd0, led_oe}, 0);
      chk("R10 led cleared", {30'd0, led_out}, 0);
      chk("R10 straps cleared", {30'd0, addr_wide, eeprom_found}, 0);
      run_reset(1'b1, 1'b1);
      reloc_addr = 32'hDEAD_0000;
      snoop_addr = 32'hDEAD_0000;
      snoop_vld  = 1'b1;
      @(negedge clk);
      chk("R10 R6 hit after recapture", {31'd0, snoop_hit}, 1);
      snoop_addr = 32'h5EAD_0000;
      @(negedge clk);
      chk("R6 top bit counts in wide", {31'd0, snoop_hit}, 0);
      snoop_vld = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule